// File: doc/BRIEF.md
# Event-Reporting Byte-Level I2C Bus Master

This block is an I2C bus master that software steers one byte at a time through three byte-wide registers: control, status and data. The block pauses after each bus event: a start, a repeated start, the end of an address byte, the end of a data byte, or a lost arbitration. At each pause it raises an interrupt flag and posts an 8-bit event code. While the flag is set and the block owns the bus, it holds SCL low. Software reads the code, loads the next byte or sets the acknowledge, start or stop controls, and then writes the flag to zero. Only that write lets the next bus phase start.

The SCL rate comes from the system clock through a divider that a 3-bit field selects. One setting of the field uses an external baud tick instead. SDA and SCL are open-drain: the block drives only pull-low enables and reads the two wires back on separate inputs. It watches its own released SDA bits for arbitration loss and waits on SCL held low by a target that stretches the clock.

Top module: `i2c_event_master`

## Requirements
- R1: After reset every control bit reads 0 and both pull-low outputs are 0. While the flag is clear, the status register reads 0xF8. Register select 0 is control, 1 is status, 2 is data, and 3 reads 0.
- R2: The control byte is laid out as bit0 rate0, bit1 rate1, bit2 ack-enable, bit3 event flag, bit4 stop request, bit5 start request, bit6 enable, bit7 rate2. The rate field {bit7,bit1,bit0} sets the SCL period in system clocks: 0 gives 256, 1 gives 224, 2 gives 192, 3 gives 160, 4 gives 960, 5 gives 120 and 6 gives 60. Code 7 gives 8 baud-tick pulses.
- R3: When the block is enabled, idle and has no pending flag, a start request makes SDA fall while SCL is high. The block then sets the flag with code 0x08.
- R4: A start request that is pending when the flag is cleared on an owned bus produces a repeated start, reported with code 0x10.
- R5: The first byte after a start or repeated start is the address byte. It goes out MSB first, and bit 0 set means a read. A write address reports 0x18 when acknowledged and 0x20 when not. A read address reports 0x40 when acknowledged and 0x48 when not. SDA changes only while SCL is held low.
- R6: A data byte sent after a write address reports 0x28 when acknowledged and 0x30 when not acknowledged.
- R7: After a read address, each flag clear receives one byte into the data register. With ack-enable at 1 the master drives ACK and reports 0x50. With ack-enable at 0 it leaves a NACK and reports 0x58.
- R8: The flag is set on every reported event and drives the interrupt output. Writing 1 to it has no effect and writing 0 clears it. While the flag is set and the bus is owned, SCL stays low and no bus phase advances.
- R9: A stop request that is pending when the flag is cleared makes SDA rise while SCL is high. The stop request then clears itself, both lines are released and no flag is raised.
- R10: A released SDA bit that reads back low during a sent byte is lost arbitration. The block reports 0x38 and releases both SCL and SDA.
- R11: Clearing enable returns the block to idle, clears the flag and releases both lines. Setting enable again makes it usable once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Event flag |
| baud_tick | input | 1 | External rate pulse, used by rate code 7 |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The bench runs all eight rate codes and measures the spacing of SCL falling edges against the period computed for each code. A bit-counting target model answers at a single address, acknowledges every written byte except 0xFF and returns a fixed pair of bytes on reads. Against this target the bench performs a write, a repeated-start read, an address to the wrong target in each direction, and a NACKed data byte. Every event code is told apart from its ACK/NACK partner in this way. A second driver that holds SDA low separates arbitration loss from an ordinary NACK. Holds with the flag set, writes of 1 to the flag, and a disable in the middle of a transfer show that only a clear of the flag lets the bus phase advance.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_RSTART = 3'd2,
        ST_BYTE   = 3'd3,
        ST_STOP   = 3'd4,
        ST_WAIT   = 3'd5
    } eng_state_e;

    localparam logic [7:0] EV_START     = 8'h08;
    localparam logic [7:0] EV_RSTART    = 8'h10;
    localparam logic [7:0] EV_WADR_ACK  = 8'h18;
    localparam logic [7:0] EV_WADR_NACK = 8'h20;
    localparam logic [7:0] EV_TX_ACK    = 8'h28;
    localparam logic [7:0] EV_TX_NACK   = 8'h30;
    localparam logic [7:0] EV_ARB       = 8'h38;
    localparam logic [7:0] EV_RADR_ACK  = 8'h40;
    localparam logic [7:0] EV_RADR_NACK = 8'h48;
    localparam logic [7:0] EV_RX_ACK    = 8'h50;
    localparam logic [7:0] EV_RX_NACK   = 8'h58;
    localparam logic [7:0] EV_NONE      = 8'hF8;

    localparam logic [2:0] RATE_EXT = 3'b111;

    // Quarter of an SCL period: system clocks, or baud pulses for RATE_EXT.
    function automatic logic [7:0] quarter_len(input logic [2:0] code);
        case (code)
            3'd0:    return 8'd64;
            3'd1:    return 8'd56;
            3'd2:    return 8'd48;
            3'd3:    return 8'd40;
            3'd4:    return 8'd240;
            3'd5:    return 8'd30;
            3'd6:    return 8'd15;
            default: return 8'd2;
        endcase
    endfunction

endpackage

// File: rtl/i2cm_rate_gen.sv
module i2cm_rate_gen
    import i2cm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ens,
    input  logic [2:0] rate_code,
    input  logic       baud_tick,
    output logic       tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } rate_t;

    rate_t q, d;
    logic [CNT_W-1:0] lim;
    logic             adv;

    always_comb begin
        lim    = CNT_W'(quarter_len(rate_code));
        adv    = (rate_code == RATE_EXT) ? baud_tick : 1'b1;
        d      = q;
        d.tick = 1'b0;
        if (!ens) begin
            d.cnt = '0;
        end else if (adv) begin
            if (q.cnt >= lim - 1'b1) begin
                d.cnt  = '0;
                d.tick = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

    // R2: no rate pulses while the block is disabled
    p_tick_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ens |=> !tick);

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ens,
    input  logic              sta,
    input  logic              sto,
    input  logic              aa,
    input  logic              tick,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_wdata,
    input  logic              si_clr,
    output logic              si,
    output logic [7:0]        status,
    output logic [BYTE_W-1:0] data,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              stop_done
);

    localparam int BIT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        eng_state_e        state;
        logic [1:0]        ph;
        logic [BIT_W-1:0]  bitn;
        logic [BYTE_W-1:0] shift;
        logic [BYTE_W-1:0] data;
        logic [7:0]        status;
        logic              si;
        logic              owner;
        logic              addr_ph;
        logic              rd;
        logic              tx;
        logic              ack;
        logic              scl_pull;
        logic              sda_pull;
        logic              stop_done;
    } eng_t;

    eng_t q, d;
    logic ack_now;

    always_comb begin
        d           = q;
        d.stop_done = 1'b0;
        ack_now     = 1'b0;
        if (data_wr) d.data = data_wdata;
        if (si_clr)  d.si   = 1'b0;

        if (!ens) begin
            d.state    = ST_IDLE;
            d.si       = 1'b0;
            d.owner    = 1'b0;
            d.addr_ph  = 1'b0;
            d.ph       = '0;
            d.scl_pull = 1'b0;
            d.sda_pull = 1'b0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    d.scl_pull = 1'b0;
                    d.sda_pull = 1'b0;
                    if (sta && !q.si) begin
                        d.state = ST_START;
                        d.ph    = '0;
                    end
                end

                ST_START: if (tick) begin
                    case (q.ph)
                        2'd0: begin d.sda_pull = 1'b1; d.ph = 2'd1; end
                        2'd1: begin d.scl_pull = 1'b1; d.ph = 2'd2; end
                        default: begin
                            d.state   = ST_WAIT;
                            d.si      = 1'b1;
                            d.status  = EV_START;
                            d.owner   = 1'b1;
                            d.addr_ph = 1'b1;
                        end
                    endcase
                end

                ST_RSTART: if (tick) begin
                    case (q.ph)
                        2'd0: begin d.sda_pull = 1'b0; d.ph = 2'd1; end
                        2'd1: begin d.scl_pull = 1'b0; d.ph = 2'd2; end
                        2'd2: if (scl_in) begin d.sda_pull = 1'b1; d.ph = 2'd3; end
                        default: begin
                            d.scl_pull = 1'b1;
                            d.state    = ST_WAIT;
                            d.si       = 1'b1;
                            d.status   = EV_RSTART;
                            d.addr_ph  = 1'b1;
                        end
                    endcase
                end

                ST_STOP: if (tick) begin
                    case (q.ph)
                        2'd0: begin d.sda_pull = 1'b1; d.ph = 2'd1; end
                        2'd1: begin d.scl_pull = 1'b0; d.ph = 2'd2; end
                        2'd2: if (scl_in) begin d.sda_pull = 1'b0; d.ph = 2'd3; end
                        default: begin
                            d.state     = ST_IDLE;
                            d.owner     = 1'b0;
                            d.stop_done = 1'b1;
                        end
                    endcase
                end

                ST_BYTE: if (tick) begin
                    case (q.ph)
                        2'd0: begin
                            if (q.bitn < BIT_W'(BYTE_W)) begin
                                d.sda_pull = q.tx ? ~q.shift[BYTE_W-1] : 1'b0;
                            end else begin
                                d.sda_pull = q.tx ? 1'b0 : aa;
                                d.ack      = aa;
                            end
                            d.ph = 2'd1;
                        end
                        2'd1: begin d.scl_pull = 1'b0; d.ph = 2'd2; end
                        2'd2: if (scl_in) d.ph = 2'd3;
                        default: begin
                            d.scl_pull = 1'b1;
                            if (q.bitn < BIT_W'(BYTE_W)) begin
                                if (q.tx && !q.sda_pull && !sda_in) begin
                                    d.scl_pull = 1'b0;
                                    d.sda_pull = 1'b0;
                                    d.owner    = 1'b0;
                                    d.addr_ph  = 1'b0;
                                    d.state    = ST_WAIT;
                                    d.si       = 1'b1;
                                    d.status   = EV_ARB;
                                end else begin
                                    d.shift = {q.shift[BYTE_W-2:0], sda_in};
                                    d.bitn  = q.bitn + 1'b1;
                                    d.ph    = 2'd0;
                                end
                            end else begin
                                ack_now = q.tx ? !sda_in : q.ack;
                                if (q.addr_ph) begin
                                    if (q.rd) d.status = ack_now ? EV_RADR_ACK : EV_RADR_NACK;
                                    else      d.status = ack_now ? EV_WADR_ACK : EV_WADR_NACK;
                                end else if (q.tx) begin
                                    d.status = ack_now ? EV_TX_ACK : EV_TX_NACK;
                                end else begin
                                    d.status = ack_now ? EV_RX_ACK : EV_RX_NACK;
                                    d.data   = q.shift;
                                end
                                d.addr_ph = 1'b0;
                                d.state   = ST_WAIT;
                                d.si      = 1'b1;
                            end
                        end
                    endcase
                end

                ST_WAIT: if (!q.si) begin
                    d.ph = '0;
                    if (!q.owner) begin
                        d.state     = sta ? ST_START : ST_IDLE;
                        d.stop_done = sto;
                    end else if (sto) begin
                        d.state = ST_STOP;
                    end else if (sta) begin
                        d.state = ST_RSTART;
                    end else begin
                        d.state = ST_BYTE;
                        d.bitn  = '0;
                        d.shift = q.data;
                        d.tx    = q.addr_ph | ~q.rd;
                        if (q.addr_ph) d.rd = q.data[0];
                    end
                end

                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign si        = q.si;
    assign status    = q.status;
    assign data      = q.data;
    assign scl_pull  = q.scl_pull;
    assign sda_pull  = q.sda_pull;
    assign stop_done = q.stop_done;

    // R8: a pending event on an owned bus keeps SCL low
    p_hold_scl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.si && q.owner) |-> q.scl_pull);

    // R10: after lost arbitration both lines are free
    p_arb_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.si && q.status == EV_ARB) |-> (!q.scl_pull && !q.sda_pull));

    // R5: inside a byte, SDA moves only while SCL is held low
    p_sda_move_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_BYTE && !$stable(q.sda_pull)) |-> q.scl_pull);

    // R11: disable empties the flag and parks the sequencer
    p_disable_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ens |=> (!q.si && q.state == ST_IDLE));

    // R1: a posted event code is one of the master codes
    p_code_class_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.si |-> (q.status[2:0] == 3'b000 && q.status >= EV_START && q.status <= EV_RX_NACK));

endmodule

// File: rtl/i2c_event_master.sv
module i2c_event_master
    import i2cm_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              baud_tick,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull
);

    typedef struct packed {
        logic [2:0] rate;
        logic       aa;
        logic       sto;
        logic       sta;
        logic       ens;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic              wr_ctl, wr_dat, si_clr;
    logic              tick, si, stop_done;
    logic [7:0]        status;
    logic [BYTE_W-1:0] data;

    assign wr_ctl = reg_wr && (reg_sel == 2'd0);
    assign wr_dat = reg_wr && (reg_sel == 2'd2);
    assign si_clr = wr_ctl && !reg_wdata[3];

    always_comb begin
        ctl_d = ctl_q;
        if (stop_done) ctl_d.sto = 1'b0;
        if (wr_ctl) begin
            ctl_d.rate = {reg_wdata[7], reg_wdata[1], reg_wdata[0]};
            ctl_d.aa   = reg_wdata[2];
            ctl_d.sto  = reg_wdata[4];
            ctl_d.sta  = reg_wdata[5];
            ctl_d.ens  = reg_wdata[6];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (reg_sel)
            2'd0:    reg_rdata = {ctl_q.rate[2], ctl_q.ens, ctl_q.sta, ctl_q.sto,
                                  si, ctl_q.aa, ctl_q.rate[1], ctl_q.rate[0]};
            2'd1:    reg_rdata = si ? status : EV_NONE;
            2'd2:    reg_rdata = data;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = si;

    i2cm_rate_gen #(.CNT_W(CNT_W)) i_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ens       (ctl_q.ens),
        .rate_code (ctl_q.rate),
        .baud_tick (baud_tick),
        .tick      (tick)
    );

    i2cm_engine #(.BYTE_W(BYTE_W)) i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .ens        (ctl_q.ens),
        .sta        (ctl_q.sta),
        .sto        (ctl_q.sto),
        .aa         (ctl_q.aa),
        .tick       (tick),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .data_wr    (wr_dat),
        .data_wdata (reg_wdata),
        .si_clr     (si_clr),
        .si         (si),
        .status     (status),
        .data       (data),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull),
        .stop_done  (stop_done)
    );

    // R9: a finished stop withdraws the stop request
    p_sto_selfclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_done && !wr_ctl) |=> !ctl_q.sto);

endmodule

// File: tb/test_i2c_event_master.sv
module test_i2c_event_master;

    localparam int BAUD_DIV = 3;
    localparam logic [6:0] SLV = 7'h5A;
    localparam int WDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       baud_tick = 1'b0;
    logic       scl_in, sda_in, scl_pull, sda_pull;
    logic       slv_pull = 1'b0;
    logic       arb_pull = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int baud_cnt = 0;

    assign scl_in = ~scl_pull;
    assign sda_in = ~(sda_pull | slv_pull | arb_pull);

    always #10 clk = ~clk;

    i2c_event_master i_i2c_event_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .baud_tick (baud_tick),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        baud_cnt  = (baud_cnt == BAUD_DIV - 1) ? 0 : baud_cnt + 1;
        baud_tick = (baud_cnt == 0);
    end

    // ---------------- target model ----------------
    int         starts = 0, stops = 0, bitn = 0, nrx = 0, nack_log = 0, ri = 0;
    logic       active = 1'b0, addr_ph = 1'b0, trans = 1'b0, match = 1'b0;
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] sh = 8'h00, txb = 8'h00;
    logic [7:0] rx_log [8];
    logic       mack_log [8];
    logic [7:0] rd_vals [2] = '{8'hC5, 8'h3A};

    always @(negedge clk) begin
        if (scl_in && p_scl && p_sda && !sda_in) begin
            starts++; active = 1'b1; addr_ph = 1'b1; trans = 1'b0;
            bitn = -1; slv_pull = 1'b0;
        end else if (scl_in && p_scl && !p_sda && sda_in) begin
            stops++; active = 1'b0; slv_pull = 1'b0;
        end else if (active) begin
            if (!p_scl && scl_in) begin
                if (bitn >= 0 && bitn < 8 && !trans) sh = {sh[6:0], sda_in};
                if (bitn == 8 && trans) begin
                    mack_log[nack_log % 8] = !sda_in; nack_log++;
                end
            end else if (p_scl && !scl_in) begin
                if (bitn == -1) begin
                    bitn = 0;
                end else if (bitn < 7) begin
                    bitn++;
                    if (trans) slv_pull = ~txb[7-bitn];
                end else if (bitn == 7) begin
                    bitn = 8;
                    if (!trans) begin
                        if (addr_ph) begin
                            match = (sh[7:1] == SLV); slv_pull = match;
                        end else begin
                            rx_log[nrx % 8] = sh; nrx++; slv_pull = (sh != 8'hFF);
                        end
                    end else slv_pull = 1'b0;
                end else begin
                    bitn = 0; slv_pull = 1'b0;
                    if (addr_ph) begin
                        addr_ph = 1'b0;
                        trans = match && sh[0];
                        if (!match) active = 1'b0;
                    end else if (trans && !mack_log[(nack_log - 1) % 8]) begin
                        trans = 1'b0; active = 1'b0;
                    end
                    if (active && trans) begin
                        txb = rd_vals[ri % 2]; ri++; slv_pull = ~txb[7];
                    end
                end
            end
        end
        p_scl = scl_in;
        p_sda = sda_in;
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] ctl(input logic en, input logic sta, input logic sto,
                                       input logic si, input logic aa, input logic [2:0] code);
        return {code[2], en, sta, sto, si, aa, code[1], code[0]};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wait_si(input string req);
        int g = 0;
        while (!irq && g < 20000) begin @(negedge clk); g++; end
        if (!irq) check(1'b0, req, 0, 1);
    endtask

    task automatic expect_code(input string req, input logic [7:0] exp);
        logic [7:0] v;
        wait_si(req);
        rd(2'd1, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic do_stop(input logic [2:0] code, input string req);
        logic [7:0] v;
        int g = 0;
        int s0 = stops;
        wr(2'd0, ctl(1, 0, 1, 0, 1, code));
        v = 8'h10;
        while (v[4] && g < 20000) begin rd(2'd0, v); g++; end
        check(!v[4], req, v, 0);
        check(!scl_pull && !sda_pull && !irq, req, {scl_pull, sda_pull, irq}, 0);
        check(stops == s0 + 1, req, stops, s0 + 1);
    endtask

    task automatic measure(output int per);
        int n = 0, t0 = 0, g = 0;
        logic pv = scl_pull;
        per = 0;
        while (n < 2 && g < 20000) begin
            @(negedge clk); g++;
            if (scl_pull && !pv) begin
                n++;
                if (n == 1) t0 = g; else per = g - t0;
            end
            pv = scl_pull;
        end
    endtask

    function automatic int period_of(input int code);
        case (code)
            0: return 256;  1: return 224;  2: return 192;  3: return 160;
            4: return 960;  5: return 120;  6: return 60;
            default: return 8 * BAUD_DIV;
        endcase
    endfunction

    always @(negedge clk) begin
        if (cyc > WDOG) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v;
        int per, s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 0);
        rd(2'd1, v); check(v == 8'hF8, "R1 status", v, 8'hF8);
        rd(2'd3, v); check(v == 8'h00, "R1 sel3", v, 0);
        check(!irq && !scl_pull && !sda_pull, "R1 lines", {irq, scl_pull, sda_pull}, 0);

        // R2: every rate code, period between SCL falls; R3/R5 each pass
        for (int c = 0; c < 8; c++) begin
            s0 = starts;
            wr(2'd0, ctl(1, 1, 0, 1, 1, 3'(c)));
            rd(2'd0, v);
            check({v[7], v[1], v[0]} == 3'(c), "R2 field", v, c);
            expect_code("R3 start", 8'h08);
            check(starts == s0 + 1, "R3 sda falls with scl high", starts, s0 + 1);
            wr(2'd2, {SLV, 1'b0});
            wr(2'd0, ctl(1, 0, 0, 0, 1, 3'(c)));
            measure(per);
            check(per == period_of(c), "R2 period", per, period_of(c));
            expect_code("R5 write addr ack", 8'h18);
            do_stop(3'(c), "R9 stop");
        end

        // Write transfer with hold checks, then repeated-start read
        wr(2'd0, ctl(1, 1, 0, 0, 1, 3'd6));
        expect_code("R3 start", 8'h08);
        wr(2'd2, {SLV, 1'b0});
        wr(2'd0, ctl(1, 0, 0, 1, 1, 3'd6));
        check(irq == 1'b1, "R8 write one keeps flag", irq, 1);
        begin
            logic held = 1'b1;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (!scl_pull || !irq) held = 1'b0;
            end
            check(held, "R8 scl held while flag set", held, 1);
        end
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R5 write addr ack", 8'h18);
        wr(2'd2, 8'h96);
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R6 data ack", 8'h28);
        wr(2'd2, 8'h3C);
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R6 data ack", 8'h28);
        check(rx_log[0] == 8'h96, "R6 byte seen", rx_log[0], 8'h96);
        check(rx_log[1] == 8'h3C, "R6 byte seen", rx_log[1], 8'h3C);

        wr(2'd0, ctl(1, 1, 0, 0, 1, 3'd6));
        expect_code("R4 repeated start", 8'h10);
        wr(2'd2, {SLV, 1'b1});
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R5 read addr ack", 8'h40);
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R7 rx ack", 8'h50);
        rd(2'd2, v); check(v == 8'hC5, "R7 rx byte", v, 8'hC5);
        check(mack_log[0] == 1'b1, "R7 master ack", mack_log[0], 1);
        wr(2'd0, ctl(1, 0, 0, 0, 0, 3'd6));
        expect_code("R7 rx nack", 8'h58);
        rd(2'd2, v); check(v == 8'h3A, "R7 rx byte", v, 8'h3A);
        check(mack_log[1] == 1'b0, "R7 master nack", mack_log[1], 0);
        do_stop(3'd6, "R9 stop after read");
        rd(2'd1, v); check(v == 8'hF8, "R1 status idle", v, 8'hF8);

        // Wrong target, both directions; NACKed data
        wr(2'd0, ctl(1, 1, 0, 0, 1, 3'd6));
        expect_code("R3 start", 8'h08);
        wr(2'd2, {7'h12, 1'b0});
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R5 write addr nack", 8'h20);
        do_stop(3'd6, "R9 stop");
        wr(2'd0, ctl(1, 1, 0, 0, 1, 3'd6));
        expect_code("R3 start", 8'h08);
        wr(2'd2, {7'h12, 1'b1});
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R5 read addr nack", 8'h48);
        do_stop(3'd6, "R9 stop");
        wr(2'd0, ctl(1, 1, 0, 0, 1, 3'd6));
        expect_code("R3 start", 8'h08);
        wr(2'd2, {SLV, 1'b0});
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R5 write addr ack", 8'h18);
        wr(2'd2, 8'hFF);
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R6 data nack", 8'h30);
        do_stop(3'd6, "R9 stop");

        // R10: another driver holds SDA low against a released bit
        wr(2'd0, ctl(1, 1, 0, 0, 1, 3'd6));
        expect_code("R3 start", 8'h08);
        wr(2'd2, {SLV, 1'b0});
        arb_pull = 1'b1;
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R10 arbitration", 8'h38);
        check(!scl_pull && !sda_pull, "R10 lines free", {scl_pull, sda_pull}, 0);
        arb_pull = 1'b0;
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        repeat (100) @(negedge clk);
        check(!irq && !scl_pull && !sda_pull, "R10 idle after clear", {irq, scl_pull, sda_pull}, 0);

        // R11: disable in the middle of a transfer
        wr(2'd0, ctl(1, 1, 0, 0, 1, 3'd6));
        expect_code("R3 start", 8'h08);
        wr(2'd0, ctl(0, 0, 0, 1, 1, 3'd6));
        rd(2'd1, v); check(v == 8'hF8, "R11 status", v, 8'hF8);
        check(!irq && !scl_pull && !sda_pull, "R11 lines", {irq, scl_pull, sda_pull}, 0);
        repeat (200) @(negedge clk);
        check(!irq && !scl_pull, "R11 stays idle", {irq, scl_pull}, 0);
        wr(2'd0, ctl(1, 1, 0, 0, 1, 3'd6));
        expect_code("R11 re-enabled start", 8'h08);
        wr(2'd2, {SLV, 1'b0});
        wr(2'd0, ctl(1, 0, 0, 0, 1, 3'd6));
        expect_code("R11 re-enabled addr", 8'h18);
        do_stop(3'd6, "R9 stop");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule